// File: doc/BRIEF.md
# Cross-Domain Mailbox Register

This block carries one 36-bit message from a sending port to a receiving port. Each port runs on its own clock, and the two clocks may be unrelated or identical. The message does not pass through any queue storage. The sender deposits a word on a rising edge of its clock when it selects the mailbox and asserts write. The receiver then sees a mail-present flag in its own clock domain. When the receiver takes the word, the flag drops. A moment later the sender sees its busy indication fall, and it may post again.

The write event crosses into the receiving domain as a level toggle through a two-flop synchronizer. The read event comes back the same way. The data register is loaded only while the mailbox is free, and it stays unchanged until the receiver has read it, so no data bit is ever synchronized. One instance serves one direction. A bidirectional link uses two instances. A single active-low reset is asserted asynchronously and released synchronously in each domain. Reset empties the mailbox.

Top module: `xdom_mailbox`

## Requirements
- R1: While reset is asserted, and right after it is released, `snd_busy` is 0, `rcv_mail` is 0 and `rcv_rdata` is all zeros.
- R2: When `snd_sel`=1, `snd_wr_en`=1 and `snd_busy`=0 at a sender clock edge, the word on `snd_wdata` is captured and `snd_busy` is 1 after that edge.
- R3: A sender edge that does not have both `snd_sel` and `snd_wr_en` high leaves `snd_busy` at 0. No mail then appears at the receiver.
- R4: A write attempted while `snd_busy`=1 is ignored. `rcv_rdata` keeps the earlier word, and only that word is delivered.
- R5: After an accepted write, `rcv_mail` rises after at least two and at most six receiver clock edges. Whenever `rcv_mail` is 1, `snd_busy` is also 1.
- R6: While `rcv_mail` is 1, `rcv_rdata` equals the word captured by the accepted write.
- R7: When `rcv_sel`=1, `rcv_rd_en`=1 and `rcv_mail`=1 at a receiver clock edge, `rcv_mail` is 0 after that edge.
- R8: A receiver edge that does not have both `rcv_sel` and `rcv_rd_en` high leaves `rcv_mail` unchanged. A read attempt while `rcv_mail`=0 has no effect at either port.
- R9: After a read, `snd_busy` stays 1 for at least one more sender edge and falls within eight sender clock edges.
- R10: While `snd_busy` is 1, the stored word does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| snd_clk | input | 1 | Sender port clock |
| rcv_clk | input | 1 | Receiver port clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| snd_sel | input | 1 | Sender selects the mailbox |
| snd_wr_en | input | 1 | Sender write enable |
| snd_wdata | input | 36 | Word to post |
| snd_busy | output | 1 | Mailbox occupied, writes are ignored |
| rcv_sel | input | 1 | Receiver selects the mailbox |
| rcv_rd_en | input | 1 | Receiver read enable |
| rcv_rdata | output | 36 | Stored word |
| rcv_mail | output | 1 | New mail present in the receiver domain |

## Verification
The bench uses two unrelated clock periods, so that both synchronizer paths meet arbitrary phase. It sends words with all bits zero, all bits one and alternating bits, to catch a register that loads or holds wrongly. It posts a second word while the mailbox is busy. A design with a missing busy guard would overwrite the first word or deliver two mails. It tries one-sided selects and enables at both ports, and a read of an empty mailbox. A design with a weak enable decode would raise mail, drop it, or release busy too early. It also applies reset in the middle of a transfer, which must leave both flags clear.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned MBX_SYNC_MIN = 2;

  typedef struct packed {
    logic busy;
    logic wr_tgl;
    logic ack_seen;
  } snd_state_t;

  typedef struct packed {
    logic mail;
    logic wr_seen;
    logic rd_tgl;
  } rcv_state_t;
endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
  parameter int unsigned STAGES = mbx_pkg::MBX_SYNC_MIN
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/mbx_snd.sv
module mbx_snd #(
  parameter int unsigned W = 36
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  input  logic         ack_tgl_s,
  output logic         busy,
  output logic         wr_tgl,
  output logic [W-1:0] data_q
);
  import mbx_pkg::*;

  snd_state_t st_q, st_d;
  logic       fire, ack_evt;

  always_comb begin
    fire    = sel & wr_en & ~st_q.busy;
    ack_evt = ack_tgl_s ^ st_q.ack_seen;
    st_d    = st_q;
    if (fire) begin
      st_d.busy   = 1'b1;
      st_d.wr_tgl = ~st_q.wr_tgl;
    end else if (ack_evt) begin
      st_d.busy     = 1'b0;
      st_d.ack_seen = ack_tgl_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    data_q <= '0;
    else if (fire) data_q <= wdata;
  end

  assign busy   = st_q.busy;
  assign wr_tgl = st_q.wr_tgl;
endmodule

// File: rtl/mbx_rcv.sv
module mbx_rcv (
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  input  logic rd_en,
  input  logic wr_tgl_s,
  output logic mail,
  output logic rd_tgl
);
  import mbx_pkg::*;

  rcv_state_t st_q, st_d;
  logic       take, new_mail;

  always_comb begin
    take     = sel & rd_en & st_q.mail;
    new_mail = wr_tgl_s ^ st_q.wr_seen;
    st_d     = st_q;
    if (new_mail) begin
      st_d.mail    = 1'b1;
      st_d.wr_seen = wr_tgl_s;
    end
    if (take) begin
      st_d.mail   = 1'b0;
      st_d.rd_tgl = ~st_q.rd_tgl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign mail   = st_q.mail;
  assign rd_tgl = st_q.rd_tgl;
endmodule

// File: rtl/xdom_mailbox.sv
module xdom_mailbox #(
  parameter int unsigned DATA_W      = 36,
  parameter int unsigned SYNC_STAGES = mbx_pkg::MBX_SYNC_MIN
) (
  input  logic              snd_clk,
  input  logic              rcv_clk,
  input  logic              rst_n,
  input  logic              snd_sel,
  input  logic              snd_wr_en,
  input  logic [DATA_W-1:0] snd_wdata,
  output logic              snd_busy,
  input  logic              rcv_sel,
  input  logic              rcv_rd_en,
  output logic [DATA_W-1:0] rcv_rdata,
  output logic              rcv_mail
);
  logic snd_rst_n, rcv_rst_n;
  logic wr_tgl, wr_tgl_s, rd_tgl, rd_tgl_s;

  mbx_sync #(.STAGES(SYNC_STAGES)) u_snd_rst (
    .clk(snd_clk), .rst_n(rst_n), .d(1'b1), .q(snd_rst_n));
  mbx_sync #(.STAGES(SYNC_STAGES)) u_rcv_rst (
    .clk(rcv_clk), .rst_n(rst_n), .d(1'b1), .q(rcv_rst_n));

  mbx_snd #(.W(DATA_W)) u_snd (
    .clk(snd_clk), .rst_n(snd_rst_n), .sel(snd_sel), .wr_en(snd_wr_en),
    .wdata(snd_wdata), .ack_tgl_s(rd_tgl_s), .busy(snd_busy),
    .wr_tgl(wr_tgl), .data_q(rcv_rdata));

  mbx_sync #(.STAGES(SYNC_STAGES)) u_wr_sync (
    .clk(rcv_clk), .rst_n(rcv_rst_n), .d(wr_tgl), .q(wr_tgl_s));

  mbx_rcv u_rcv (
    .clk(rcv_clk), .rst_n(rcv_rst_n), .sel(rcv_sel), .rd_en(rcv_rd_en),
    .wr_tgl_s(wr_tgl_s), .mail(rcv_mail), .rd_tgl(rd_tgl));

  mbx_sync #(.STAGES(SYNC_STAGES)) u_rd_sync (
    .clk(snd_clk), .rst_n(snd_rst_n), .d(rd_tgl), .q(rd_tgl_s));
endmodule

// File: rtl/xdom_mailbox_chk.sv
module xdom_mailbox_chk #(
  parameter int unsigned DATA_W = 36
) (
  input logic              snd_clk,
  input logic              rcv_clk,
  input logic              rst_n,
  input logic              snd_sel,
  input logic              snd_wr_en,
  input logic              snd_busy,
  input logic              rcv_sel,
  input logic              rcv_rd_en,
  input logic [DATA_W-1:0] rcv_rdata,
  input logic              rcv_mail
);
  p_busy_set_r2: assert property (@(posedge snd_clk) disable iff (!rst_n)
    (snd_sel && snd_wr_en && !snd_busy) |=> snd_busy);

  p_idle_stays_r3: assert property (@(posedge snd_clk) disable iff (!rst_n)
    (!snd_busy && !(snd_sel && snd_wr_en)) |=> !snd_busy);

  p_word_held_r10: assert property (@(posedge snd_clk) disable iff (!rst_n)
    snd_busy |=> $stable(rcv_rdata));

  p_mail_owns_busy_r5: assert property (@(posedge rcv_clk) disable iff (!rst_n)
    rcv_mail |-> snd_busy);

  p_read_clears_r7: assert property (@(posedge rcv_clk) disable iff (!rst_n)
    (rcv_sel && rcv_rd_en && rcv_mail) |=> !rcv_mail);

  p_mail_kept_r8: assert property (@(posedge rcv_clk) disable iff (!rst_n)
    (rcv_mail && !(rcv_sel && rcv_rd_en)) |=> rcv_mail);
endmodule

bind xdom_mailbox xdom_mailbox_chk #(.DATA_W(DATA_W)) u_chk (
  .snd_clk(snd_clk), .rcv_clk(rcv_clk), .rst_n(rst_n),
  .snd_sel(snd_sel), .snd_wr_en(snd_wr_en), .snd_busy(snd_busy),
  .rcv_sel(rcv_sel), .rcv_rd_en(rcv_rd_en), .rcv_rdata(rcv_rdata),
  .rcv_mail(rcv_mail));

// File: tb/test_xdom_mailbox.sv
module test_xdom_mailbox;
  localparam int W = 36;

  typedef struct packed {
    logic [W-1:0] d;
    logic         sel;
    logic         en;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{36'h0_0000_0000, 1'b1, 1'b1},
    '{36'hF_FFFF_FFFF, 1'b1, 1'b1},
    '{36'hA_AAAA_AAAA, 1'b0, 1'b1},
    '{36'h5_5555_5555, 1'b1, 1'b1},
    '{36'h1_2345_6789, 1'b1, 1'b0},
    '{36'hA_AAAA_AAAA, 1'b1, 1'b1},
    '{36'h8_0000_0001, 1'b1, 1'b1}
  };

  logic snd_clk = 1'b0, rcv_clk = 1'b0, rst_n = 1'b0;
  logic snd_sel = 1'b0, snd_wr_en = 1'b0, rcv_sel = 1'b0, rcv_rd_en = 1'b0;
  logic [W-1:0] snd_wdata = '0;
  logic [W-1:0] rcv_rdata;
  logic snd_busy, rcv_mail;

  int n_chk = 0, n_bad = 0;

  always #2.5 snd_clk = ~snd_clk;
  always #3.5 rcv_clk = ~rcv_clk;

  xdom_mailbox i_xdom_mailbox (
    .snd_clk(snd_clk), .rcv_clk(rcv_clk), .rst_n(rst_n),
    .snd_sel(snd_sel), .snd_wr_en(snd_wr_en), .snd_wdata(snd_wdata),
    .snd_busy(snd_busy), .rcv_sel(rcv_sel), .rcv_rd_en(rcv_rd_en),
    .rcv_rdata(rcv_rdata), .rcv_mail(rcv_mail));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic post(input logic [W-1:0] d, input logic s, input logic e);
    @(negedge snd_clk);
    snd_sel = s; snd_wr_en = e; snd_wdata = d;
    @(negedge snd_clk);
    snd_sel = 1'b0; snd_wr_en = 1'b0;
  endtask

  task automatic take(input logic s, input logic e);
    @(negedge rcv_clk);
    rcv_sel = s; rcv_rd_en = e;
    @(negedge rcv_clk);
    rcv_sel = 1'b0; rcv_rd_en = 1'b0;
  endtask

  task automatic wait_mail(output int n);
    n = 0;
    while (!rcv_mail && n < 10) begin
      @(negedge rcv_clk);
      n++;
    end
  endtask

  task automatic wait_free(output int n);
    n = 0;
    while (snd_busy && n < 12) begin
      @(negedge snd_clk);
      n++;
    end
  endtask

  task automatic full_transfer(input logic [W-1:0] d);
    int n;
    post(d, 1'b1, 1'b1);
    check("R2 busy after accepted write", snd_busy, 1);
    wait_mail(n);
    check("R5 mail latency in range", (n >= 2 && n <= 6), 1);
    check("R6 delivered word", rcv_rdata, d);
    take(1'b1, 1'b1);
    check("R7 mail cleared by read", rcv_mail, 0);
    wait_free(n);
    check("R9 busy released in bound", (n >= 1 && n <= 8), 1);
  endtask

  initial begin
    int n;
    #150000;
    n_bad++;
    n_chk++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge snd_clk);
    check("R1 busy in reset", snd_busy, 0);
    check("R1 mail in reset", rcv_mail, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge rcv_clk);
    check("R1 busy after reset", snd_busy, 0);
    check("R1 mail after reset", rcv_mail, 0);
    check("R1 word after reset", rcv_rdata, 0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].sel && VEC[i].en) full_transfer(VEC[i].d);
      else begin
        post(VEC[i].d, VEC[i].sel, VEC[i].en);
        check("R3 one-sided write leaves busy low", snd_busy, 0);
        repeat (7) @(negedge rcv_clk);
        check("R3 no mail from one-sided write", rcv_mail, 0);
      end
    end

    // R4: second write while busy is dropped
    post(36'h3_1111_2222, 1'b1, 1'b1);
    post(36'hC_3333_4444, 1'b1, 1'b1);
    check("R4 stored word kept while busy", rcv_rdata, 36'h3_1111_2222);
    wait_mail(n);
    check("R4 first word delivered", rcv_rdata, 36'h3_1111_2222);
    // R8: one-sided reads leave mail set
    take(1'b1, 1'b0);
    check("R8 sel alone keeps mail", rcv_mail, 1);
    take(1'b0, 1'b1);
    check("R8 enable alone keeps mail", rcv_mail, 1);
    check("R10 word still held", rcv_rdata, 36'h3_1111_2222);
    take(1'b1, 1'b1);
    check("R7 mail cleared", rcv_mail, 0);
    wait_free(n);
    check("R9 busy released", snd_busy, 0);
    repeat (8) @(negedge rcv_clk);
    check("R4 no second mail", rcv_mail, 0);
    check("R4 dropped word not stored", rcv_rdata, 36'h3_1111_2222);

    // R8: read of empty mailbox has no effect
    take(1'b1, 1'b1);
    repeat (8) @(negedge snd_clk);
    check("R8 empty read keeps mail low", rcv_mail, 0);
    check("R8 empty read keeps busy low", snd_busy, 0);
    full_transfer(36'h7_0F0F_0F0F);

    // R1: reset mid-transfer
    post(36'h9_9999_9999, 1'b1, 1'b1);
    wait_mail(n);
    @(negedge snd_clk);
    rst_n = 1'b0;
    @(negedge rcv_clk);
    check("R1 busy cleared by reset", snd_busy, 0);
    check("R1 mail cleared by reset", rcv_mail, 0);
    check("R1 word cleared by reset", rcv_rdata, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge rcv_clk);
    full_transfer(36'h2_4681_3579);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule